// File: doc/BRIEF.md
# Smart-Card Receive Byte Queue with Parity-Error Accounting

This block sits behind the character receiver of a smart-card interface. Each received character arrives as a one-cycle strobe with its byte and a parity-error indication. The block keeps good bytes in a small first-in first-out queue. The host sets the usable depth of the queue, from 1 to 8 entries. The host reads bytes one at a time through a read strobe.

Parity errors are handled according to the selected transmission protocol. In the character protocol (T=0), a byte with an error is thrown away and counted. The parity-error flag rises only when the count reaches a threshold the host has loaded. After that the counter stops until the host loads the threshold again. In the block protocol (T=1), a byte with an error is kept and the flag rises at once. An active-low interrupt is asserted while the queue holds its programmed number of bytes, or while the parity-error flag is set. In synchronous-card mode the queue is bypassed, and a read returns the live card line level in bit 0.

Top module: `sc_rx_fifo`

## Requirements
- R1: After reset, the queue is empty, `emptyFlag` is 1, and `fullFlag`, `parErrFlag` and `overrunFlag` are 0. `intN` is 1 and `rdData` is 0. The threshold counts as 1 and the counter is armed.
- R2: The effective depth is `depthCfg`, with 0 treated as 1 and values above 8 treated as 8. `fullFlag` is 1 exactly when the stored count is at least the effective depth, and it drops after a read brings the count below it. `intN` is 0 whenever `fullFlag` or `parErrFlag` is 1, and 1 otherwise.
- R3: Bytes leave in arrival order. `rdData` shows the oldest stored byte without delay, or 0 when the queue is empty. A `rdStrobe` removes that byte, and a read of an empty queue changes nothing. `emptyFlag` is 1 exactly when nothing is stored.
- R4: With `protoT1`=0, a byte that arrives with `rxParErr`=1 is not stored, and the armed error counter advances by one. When the counter reaches the threshold, `parErrFlag` goes to 1 on the next cycle.
- R5: Once the threshold is reached, the counter is disarmed and ignores further errors. `parErrFlag` holds. A `thrLoad` strobe loads `thrCfg` as the threshold (0 taken as 1, above 8 taken as 8), clears the counter and `parErrFlag`, and re-arms the counter. In that cycle the strobe overrides any parity event.
- R6: With `protoT1`=1, a byte with `rxParErr`=1 is stored like a good byte, and `parErrFlag` goes to 1 on the next cycle whatever the threshold is.
- R7: A byte that would be stored is discarded when the count is at or above the effective depth and no read is accepted in that cycle. The discard sets the sticky `overrunFlag`. `statRd` clears `overrunFlag`, unless a new discard happens in the same cycle.
- R8: With `syncMode`=1, `rdData` is `cardIo` in bit 0 and zero in every other bit. `rdStrobe` does not remove a byte from the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | One-cycle strobe for a received character |
| rxData | input | 8 | Received byte |
| rxParErr | input | 1 | The received byte failed its parity check |
| protoT1 | input | 1 | 0 selects T=0 handling, 1 selects T=1 handling |
| syncMode | input | 1 | Synchronous-card mode: the queue is bypassed on reads |
| cardIo | input | 1 | Live card data line level |
| depthCfg | input | 4 | Programmed usable queue depth |
| thrCfg | input | 4 | Parity-error threshold value |
| thrLoad | input | 1 | Loads the threshold and re-arms the error counter |
| rdStrobe | input | 1 | Host read of the data register |
| statRd | input | 1 | Host read of status; clears the overrun flag |
| rdData | output | 8 | Oldest stored byte, or the card line in synchronous mode |
| fullFlag | output | 1 | The queue holds the effective depth or more |
| emptyFlag | output | 1 | The queue holds nothing |
| parErrFlag | output | 1 | Parity-error status |
| overrunFlag | output | 1 | Sticky flag: a byte was discarded for lack of room |
| intN | output | 1 | Interrupt, active low |

## Verification
The bench builds the block with its default parameters: 8-bit data, 8 storage entries, and 4-bit configuration fields. The 4-bit fields let the random stimulus reach the clamped settings 0 and 9 to 15 for both depth and threshold. Because the storage has 8 entries, every depth from 1 to the maximum can be filled. Overrun then shows up at each of those depths. Depth changes while bytes are stored test the rule that full means at least the effective depth. Thresholds up to 8 can be reached within the run, so the disarm and reload sequence is exercised often, including reloads that land in the same cycle as a parity event.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  // Strobes issued by the control unit to the byte storage.
  typedef struct packed {
    logic push;
    logic pop;
  } rxStrb_t;

endpackage

// File: rtl/sc_rx_ctrl.sv
module sc_rx_ctrl #(
  parameter int MAX_DEPTH = 8,
  parameter int CFG_W     = 4,
  parameter int THR_MAX   = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             rxValid,
  input  logic                             rxParErr,
  input  logic                             protoT1,
  input  logic                             syncMode,
  input  logic [CFG_W-1:0]                 depthCfg,
  input  logic [CFG_W-1:0]                 thrCfg,
  input  logic                             thrLoad,
  input  logic                             rdStrobe,
  input  logic                             statRd,
  input  logic [$clog2(MAX_DEPTH+1)-1:0]   count,
  output sc_rx_pkg::rxStrb_t               strb,
  output logic                             fullFlag,
  output logic                             emptyFlag,
  output logic                             parErrFlag,
  output logic                             overrunFlag,
  output logic                             intN
);

  localparam int CNT_W = $clog2(MAX_DEPTH + 1);
  localparam int ERR_W = $clog2(THR_MAX + 1);
  localparam logic [CFG_W-1:0] DEPTH_LIM = CFG_W'(MAX_DEPTH);
  localparam logic [CFG_W-1:0] THR_LIM   = CFG_W'(THR_MAX);
  localparam logic [CNT_W-1:0] CNT_ZERO  = '0;

  logic [CNT_W-1:0] effDepth;
  logic [ERR_W-1:0] thrClamp;
  logic [ERR_W-1:0] thrReg;
  logic [ERR_W-1:0] errCnt;
  logic [ERR_W-1:0] errNext;
  logic             armed;
  logic             peReg;
  logic             ovReg;
  logic             popOk;
  logic             goodByte;
  logic             room;
  logic             ovSet;
  logic             t0Err;
  logic             t1Err;
  logic             thrHit;

  // Configuration clamping.
  always_comb begin
    if (depthCfg == '0)
      effDepth = CNT_W'(1);
    else if (depthCfg > DEPTH_LIM)
      effDepth = CNT_W'(MAX_DEPTH);
    else
      effDepth = CNT_W'(depthCfg);
  end

  always_comb begin
    if (thrCfg == '0)
      thrClamp = ERR_W'(1);
    else if (thrCfg > THR_LIM)
      thrClamp = ERR_W'(THR_MAX);
    else
      thrClamp = ERR_W'(thrCfg);
  end

  // Queue admission.
  always_comb begin
    popOk    = rdStrobe && !syncMode && (count != CNT_ZERO);
    goodByte = rxValid && (!rxParErr || protoT1);
    room     = (count < effDepth) || popOk;
    strb.push = goodByte && room;
    strb.pop  = popOk;
    ovSet     = goodByte && !room;
  end

  // Parity-error events.
  always_comb begin
    t0Err   = rxValid && rxParErr && !protoT1 && !thrLoad && armed;
    t1Err   = rxValid && rxParErr && protoT1 && !thrLoad;
    errNext = errCnt + ERR_W'(1);
    thrHit  = t0Err && (errNext == thrReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrReg <= ERR_W'(1);
      errCnt <= '0;
      armed  <= 1'b1;
      peReg  <= 1'b0;
    end else if (thrLoad) begin
      thrReg <= thrClamp;
      errCnt <= '0;
      armed  <= 1'b1;
      peReg  <= 1'b0;
    end else begin
      if (t0Err)
        errCnt <= errNext;
      if (thrHit)
        armed <= 1'b0;
      if (thrHit || t1Err)
        peReg <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ovReg <= 1'b0;
    else if (ovSet)
      ovReg <= 1'b1;
    else if (statRd)
      ovReg <= 1'b0;
  end

  // Status outputs.
  always_comb begin
    fullFlag    = (count >= effDepth);
    emptyFlag   = (count == CNT_ZERO);
    parErrFlag  = peReg;
    overrunFlag = ovReg;
    intN        = !(fullFlag || peReg);
  end

  // Checks on control behaviour.
  AST_T0_NOT_STORED: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxParErr && !protoT1) |-> !strb.push); // R4

  AST_DISARMED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !thrLoad) |=> $stable(errCnt)); // R5

  AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (parErrFlag && !thrLoad) |=> parErrFlag); // R5

  AST_T1_PE_AT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxParErr && protoT1 && !thrLoad) |=> parErrFlag); // R6

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrunFlag && !statRd) |=> overrunFlag); // R7

  AST_NO_POP_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    syncMode |-> !strb.pop); // R8

endmodule

// File: rtl/sc_rx_dpath.sv
module sc_rx_dpath #(
  parameter int DATA_W    = 8,
  parameter int MAX_DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  sc_rx_pkg::rxStrb_t               strb,
  input  logic [DATA_W-1:0]                wrData,
  input  logic                             syncMode,
  input  logic                             cardIo,
  output logic [DATA_W-1:0]                rdData,
  output logic [$clog2(MAX_DEPTH+1)-1:0]   count
);

  localparam int CNT_W = $clog2(MAX_DEPTH + 1);
  localparam int PTR_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MAX_DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [DATA_W-1:0] mem [MAX_DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [DATA_W-1:0] headData;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_DEPTH; i++)
        mem[i] <= '0;
      wrPtr <= '0;
    end else if (strb.push) begin
      mem[wrPtr] <= wrData;
      wrPtr      <= ptrInc(wrPtr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdPtr <= '0;
    else if (strb.pop)
      rdPtr <= ptrInc(rdPtr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      count <= '0;
    else begin
      case ({strb.push, strb.pop})
        2'b10:   count <= count + CNT_ONE;
        2'b01:   count <= count - CNT_ONE;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    headData = (count == '0) ? '0 : mem[rdPtr];
    if (syncMode)
      rdData = {{(DATA_W-1){1'b0}}, cardIo};
    else
      rdData = headData;
  end

  // Checks on storage behaviour.
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(MAX_DEPTH)); // R2

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> (count != '0)); // R3

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.pop) |=> (count == $past(count) + CNT_ONE)); // R3

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push) |=> (count == $past(count) - CNT_ONE)); // R3

endmodule

// File: rtl/sc_rx_fifo.sv
module sc_rx_fifo #(
  parameter int DATA_W    = 8,
  parameter int MAX_DEPTH = 8,
  parameter int CFG_W     = 4,
  parameter int THR_MAX   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParErr,
  input  logic              protoT1,
  input  logic              syncMode,
  input  logic              cardIo,
  input  logic [CFG_W-1:0]  depthCfg,
  input  logic [CFG_W-1:0]  thrCfg,
  input  logic              thrLoad,
  input  logic              rdStrobe,
  input  logic              statRd,
  output logic [DATA_W-1:0] rdData,
  output logic              fullFlag,
  output logic              emptyFlag,
  output logic              parErrFlag,
  output logic              overrunFlag,
  output logic              intN
);

  localparam int CNT_W = $clog2(MAX_DEPTH + 1);

  sc_rx_pkg::rxStrb_t strb;
  logic [CNT_W-1:0]   count;

  sc_rx_ctrl #(
    .MAX_DEPTH (MAX_DEPTH),
    .CFG_W     (CFG_W),
    .THR_MAX   (THR_MAX)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rxValid     (rxValid),
    .rxParErr    (rxParErr),
    .protoT1     (protoT1),
    .syncMode    (syncMode),
    .depthCfg    (depthCfg),
    .thrCfg      (thrCfg),
    .thrLoad     (thrLoad),
    .rdStrobe    (rdStrobe),
    .statRd      (statRd),
    .count       (count),
    .strb        (strb),
    .fullFlag    (fullFlag),
    .emptyFlag   (emptyFlag),
    .parErrFlag  (parErrFlag),
    .overrunFlag (overrunFlag),
    .intN        (intN)
  );

  sc_rx_dpath #(
    .DATA_W    (DATA_W),
    .MAX_DEPTH (MAX_DEPTH)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (rxData),
    .syncMode (syncMode),
    .cardIo   (cardIo),
    .rdData   (rdData),
    .count    (count)
  );

endmodule

// File: tb/sim_sc_rx_fifo.sv
module sim_sc_rx_fifo;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxParErr = 1'b0;
  logic       protoT1 = 1'b0;
  logic       syncMode = 1'b0;
  logic       cardIo = 1'b0;
  logic [3:0] depthCfg = 4'd8;
  logic [3:0] thrCfg = 4'd1;
  logic       thrLoad = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       statRd = 1'b0;
  logic [7:0] rdData;
  logic       fullFlag, emptyFlag, parErrFlag, overrunFlag, intN;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference state
  logic [7:0] mq[$];
  int  mErr, mThr;
  bit  mArmed, mPe, mOv;

  always #2 clk = ~clk;

  sc_rx_fifo u0 (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .rxParErr(rxParErr), .protoT1(protoT1), .syncMode(syncMode),
    .cardIo(cardIo), .depthCfg(depthCfg), .thrCfg(thrCfg),
    .thrLoad(thrLoad), .rdStrobe(rdStrobe), .statRd(statRd),
    .rdData(rdData), .fullFlag(fullFlag), .emptyFlag(emptyFlag),
    .parErrFlag(parErrFlag), .overrunFlag(overrunFlag), .intN(intN)
  );

  function automatic int clampCfg(int v, int mx);
    if (v == 0) return 1;
    if (v > mx) return mx;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mq.delete();
    mErr = 0; mThr = 1; mArmed = 1; mPe = 0; mOv = 0;
  endtask

  task automatic modelStep();
    bit popOk, good, room;
    int eff;
    if (!rstN) begin
      modelReset();
      return;
    end
    eff   = clampCfg(int'(depthCfg), 8);
    popOk = rdStrobe && !syncMode && (mq.size() > 0);
    good  = rxValid && (!rxParErr || protoT1);
    room  = (mq.size() < eff) || popOk;
    if (popOk) void'(mq.pop_front());
    if (good && room) mq.push_back(rxData);
    if (good && !room) mOv = 1;
    else if (statRd) mOv = 0;
    if (thrLoad) begin
      mThr = clampCfg(int'(thrCfg), 8);
      mErr = 0; mArmed = 1; mPe = 0;
    end else if (rxValid && rxParErr) begin
      if (protoT1) mPe = 1;
      else if (mArmed) begin
        mErr++;
        if (mErr == mThr) begin mPe = 1; mArmed = 0; end
      end
    end
  endtask

  task automatic compareAll();
    int eff;
    logic [7:0] expRd;
    bit expFull;
    eff = clampCfg(int'(depthCfg), 8);
    if (syncMode) expRd = {7'b0, cardIo};
    else expRd = (mq.size() > 0) ? mq[0] : 8'h00;
    expFull = (mq.size() >= eff);
    check(rdData == expRd, syncMode ? "R8" : "R3", "rdData", int'(rdData), int'(expRd));
    check(fullFlag == expFull, "R2", "fullFlag", int'(fullFlag), int'(expFull));
    check(emptyFlag == (mq.size() == 0), "R3", "emptyFlag", int'(emptyFlag), int'(mq.size() == 0));
    check(parErrFlag == mPe, protoT1 ? "R6" : "R4", "parErrFlag", int'(parErrFlag), int'(mPe));
    check(overrunFlag == mOv, "R7", "overrunFlag", int'(overrunFlag), int'(mOv));
    check(intN == !(expFull || mPe), "R2", "intN", int'(intN), int'(!(expFull || mPe)));
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    rxValid = 0; rxParErr = 0; thrLoad = 0; rdStrobe = 0; statRd = 0;
  endtask

  task automatic sendByte(logic [7:0] d, bit pe);
    idle(); rxValid = 1; rxData = d; rxParErr = pe; cyc(); idle();
  endtask

  task automatic readOne();
    idle(); rdStrobe = 1; cyc(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog act=timeout exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(emptyFlag == 1, "R1", "emptyFlag", int'(emptyFlag), 1);
    check(fullFlag == 0, "R1", "fullFlag", int'(fullFlag), 0);
    check(parErrFlag == 0, "R1", "parErrFlag", int'(parErrFlag), 0);
    check(overrunFlag == 0, "R1", "overrunFlag", int'(overrunFlag), 0);
    check(intN == 1, "R1", "intN", int'(intN), 1);
    check(rdData == 0, "R1", "rdData", int'(rdData), 0);

    // R2/R7: depth 3, fourth byte overruns
    depthCfg = 4'd3;
    sendByte(8'hA1, 0); sendByte(8'hB2, 0);
    check(fullFlag == 0, "R2", "fullFlag below depth", int'(fullFlag), 0);
    sendByte(8'hC3, 0);
    check(fullFlag == 1 && intN == 0, "R2", "full+intN", int'({fullFlag, intN}), 2);
    sendByte(8'hD4, 0);
    check(overrunFlag == 1, "R7", "overrunFlag", int'(overrunFlag), 1);
    idle(); statRd = 1; cyc(); idle();
    check(overrunFlag == 0, "R7", "overrun cleared", int'(overrunFlag), 0);
    check(rdData == 8'hA1, "R3", "head order", int'(rdData), 'hA1);
    readOne();
    check(fullFlag == 0 && rdData == 8'hB2, "R2", "full drops after read", int'(fullFlag), 0);
    readOne(); readOne(); readOne();
    check(emptyFlag == 1 && rdData == 0, "R3", "empty read no effect", int'(rdData), 0);

    // R4/R5: T=0 threshold 2
    depthCfg = 4'd8; protoT1 = 0;
    idle(); thrCfg = 4'd2; thrLoad = 1; cyc(); idle();
    sendByte(8'h11, 1);
    check(parErrFlag == 0 && emptyFlag == 1, "R4", "first error dropped", int'(parErrFlag), 0);
    sendByte(8'h22, 1);
    check(parErrFlag == 1 && intN == 0, "R4", "threshold reached", int'(parErrFlag), 1);
    sendByte(8'h33, 1);
    check(parErrFlag == 1 && emptyFlag == 1, "R5", "disarmed, flag held", int'(parErrFlag), 1);
    idle(); thrCfg = 4'd0; thrLoad = 1; cyc(); idle();
    check(parErrFlag == 0 && intN == 1, "R5", "reload clears", int'(parErrFlag), 0);
    sendByte(8'h44, 1);
    check(parErrFlag == 1, "R5", "threshold 0 acts as 1", int'(parErrFlag), 1);
    idle(); thrCfg = 4'd3; thrLoad = 1; cyc(); idle();

    // R6: T=1 parity error stored and flagged at once
    protoT1 = 1;
    sendByte(8'h5A, 1);
    check(parErrFlag == 1 && rdData == 8'h5A, "R6", "stored and flagged", int'(rdData), 'h5A);

    // R8: synchronous mode
    syncMode = 1; cardIo = 1;
    readOne();
    check(rdData == 8'h01, "R8", "live line bit", int'(rdData), 1);
    syncMode = 0; cardIo = 0;
    idle(); cyc();
    check(rdData == 8'h5A, "R8", "read did not pop", int'(rdData), 'h5A);
    idle(); thrLoad = 1; cyc(); idle();

    // Random phase
    for (int n = 0; n < 5000; n++) begin
      rxValid  = ($urandom % 100) < 40;
      rxData   = 8'($urandom);
      rxParErr = ($urandom % 100) < 20;
      rdStrobe = ($urandom % 100) < 25;
      statRd   = ($urandom % 100) < 10;
      thrLoad  = ($urandom % 100) < 4;
      thrCfg   = 4'($urandom);
      cardIo   = 1'($urandom);
      if (($urandom % 100) < 3) depthCfg = 4'($urandom);
      if (($urandom % 100) < 2) protoT1 = ~protoT1;
      if (($urandom % 100) < 3) syncMode = ~syncMode;
      cyc();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule